// File: doc/BRIEF.md
# Serial-In Latched Parallel-Out Shift Register

This block turns a serial bit stream into a parallel word using two register stages. Each rising edge of a shift clock moves one bit from the serial input into a shift chain. A separate rising edge of a storage clock copies the whole chain into a storage bank, and the storage bank feeds the parallel outputs. The last stage of the chain is also brought out as a serial output, so several instances can be chained into one longer register.

An active-low clear empties the shift chain at once, without waiting for a clock. It leaves the storage bank alone. An active-low output enable decides whether the parallel outputs are driven. The outputs have three states. Each output bit is given as a data value plus a per-bit drive flag, so a pad ring or a bench can build the high-impedance state from the two signals. The word width is a parameter, with a default of 8.

Top module: `sipo_latch_reg`

## Requirements
- R1: On each rising edge of `shift_clk` while `clr_n` is high, stage 0 takes `ser_in` and every stage i takes the old value of stage i-1.
- R2: On each rising edge of `store_clk`, the storage bank takes the value the shift chain held just before that edge. `par_data` always shows the storage bank, with bit i coming from shift stage i.
- R3: `ser_out` equals the top shift stage (bit WIDTH-1). It follows that stage whatever the level of `oe_n`.
- R4: A low level on `clr_n` forces every shift stage to 0 at once, with no clock edge needed. While `clr_n` is low, `shift_clk` edges leave the chain at zero.
- R5: Asserting `clr_n` leaves the storage bank, and so `par_data`, unchanged.
- R6: A `store_clk` edge taken while `clr_n` is low loads all zeros into the storage bank.
- R7: `par_drive` bit i is 1 (driven) for every bit while `oe_n` is low, and 0 (high impedance) for every bit while `oe_n` is high.
- R8: Toggling `oe_n` changes neither the shift chain nor the storage bank. Both `ser_out` and `par_data` keep their values across the toggles.
- R9: When `shift_clk` and `store_clk` rise together, the storage bank receives the chain as it stood before that shift, so the storage bank lags the chain by exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift chain clock, active on the rising edge |
| store_clk | input | 1 | Storage bank clock, active on the rising edge |
| clr_n | input | 1 | Asynchronous clear of the shift chain, active low |
| oe_n | input | 1 | Parallel output enable, active low |
| ser_in | input | 1 | Serial data into stage 0 |
| par_data | output | WIDTH | Storage bank contents |
| par_drive | output | WIDTH | Per-bit drive flag, 1 = driven and 0 = high impedance |
| ser_out | output | 1 | Top shift stage, used for cascading |

## Verification
The shift-path properties assume that every assertion of `clr_n` covers at least one `shift_clk` edge. They also assume that `clr_n` and `ser_in` never change at the same instant as a clock edge. Without the first condition, a clear released between two shift edges would break the one-edge history these properties compare against. The stimulus changes inputs only half a period away from clock edges. The random clear operation always holds `clr_n` low across one shift pulse and one optional storage pulse, so both conditions hold for the whole run.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

   parameter int unsigned SIPO_DEF_WIDTH = 8;

   typedef enum logic {
      DRV_OFF = 1'b0,
      DRV_ON  = 1'b1
   } drive_e;

endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
   parameter int unsigned WIDTH = sipo_pkg::SIPO_DEF_WIDTH
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             din,
   output logic [WIDTH-1:0] stages,
   output logic             tap
);

   localparam int unsigned TOP = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("sipo_shift_chain: WIDTH must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) stages[0] <= 1'b0;
            else        stages[0] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) stages[i] <= 1'b0;
            else        stages[i] <= stages[i-1];
         end
      end
   end

   assign tap = stages[TOP];

   AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!clr_n)
      clr_n |=> (stages[0] == $past(din)))
      else $error("serial input not captured in stage 0"); // R1

   AST_TAP_ADVANCE: assert property (@(posedge clk) disable iff (!clr_n)
      clr_n |=> (tap == $past(stages[TOP-1])))
      else $error("cascade tap did not advance"); // R3

   AST_CLEAR_EMPTY: assert property (@(posedge clk)
      !clr_n |-> (stages == '0))
      else $error("shift chain not empty during clear"); // R4

endmodule

// File: rtl/sipo_store_bank.sv
module sipo_store_bank #(
   parameter int unsigned WIDTH = sipo_pkg::SIPO_DEF_WIDTH
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("sipo_store_bank: WIDTH must be at least 1");
   end

   always_ff @(posedge clk) begin
      q <= d;
   end

endmodule

// File: rtl/sipo_drive_gate.sv
module sipo_drive_gate #(
   parameter int unsigned WIDTH = sipo_pkg::SIPO_DEF_WIDTH
) (
   input  logic             oe_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out,
   output logic [WIDTH-1:0] drv
);

   import sipo_pkg::*;

   drive_e lane_state;

   always_comb begin
      lane_state = oe_n ? DRV_OFF : DRV_ON;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      assign d_out[i] = d_in[i];
      assign drv[i]   = lane_state;
   end

endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg #(
   parameter int unsigned WIDTH = sipo_pkg::SIPO_DEF_WIDTH
) (
   input  logic             shift_clk,
   input  logic             store_clk,
   input  logic             clr_n,
   input  logic             oe_n,
   input  logic             ser_in,
   output logic [WIDTH-1:0] par_data,
   output logic [WIDTH-1:0] par_drive,
   output logic             ser_out
);

   localparam logic [WIDTH-1:0] ALL_ON = {WIDTH{1'b1}};

   if (WIDTH < 2) begin : g_bad_width
      $error("sipo_latch_reg: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] chain_q;
   logic [WIDTH-1:0] bank_q;

   sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
      .clk    (shift_clk),
      .clr_n  (clr_n),
      .din    (ser_in),
      .stages (chain_q),
      .tap    (ser_out)
   );

   sipo_store_bank #(.WIDTH(WIDTH)) u_bank (
      .clk (store_clk),
      .d   (chain_q),
      .q   (bank_q)
   );

   sipo_drive_gate #(.WIDTH(WIDTH)) u_gate (
      .oe_n  (oe_n),
      .d_in  (bank_q),
      .d_out (par_data),
      .drv   (par_drive)
   );

   AST_STORE_COPY: assert property (@(posedge store_clk) disable iff (!clr_n)
      1'b1 |=> (par_data == $past(chain_q)))
      else $error("storage bank did not copy shift chain"); // R2

   AST_DRIVE_UNIFORM: assert property (@(posedge store_clk) disable iff (!clr_n)
      (par_drive == '0) || (par_drive == ALL_ON))
      else $error("drive flags not uniform"); // R7

endmodule

// File: tb/sipo_latch_reg_tb.sv
module sipo_latch_reg_tb_top;

   localparam int  CLK_PERIOD = 10;
   localparam int  HALF       = CLK_PERIOD / 2;
   localparam int  W          = 8;
   localparam int  N_RANDOM   = 400;

   logic          shift_clk = 1'b0;
   logic          store_clk = 1'b0;
   logic          clr_n     = 1'b0;
   logic          oe_n      = 1'b1;
   logic          ser_in    = 1'b0;
   logic [W-1:0]  par_data;
   logic [W-1:0]  par_drive;
   logic          ser_out;

   int            checks = 0;
   int            errors = 0;
   bit            done   = 1'b0;
   logic [W-1:0]  exp_sr = '0;
   logic [W-1:0]  exp_st = '0;

   sipo_latch_reg #(.WIDTH(W)) dut_i (
      .shift_clk (shift_clk),
      .store_clk (store_clk),
      .clr_n     (clr_n),
      .oe_n      (oe_n),
      .ser_in    (ser_in),
      .par_data  (par_data),
      .par_drive (par_drive),
      .ser_out   (ser_out)
   );

   function automatic logic [W-1:0] shifted(input logic [W-1:0] cur, input logic b);
      return {cur[W-2:0], b};
   endfunction

   function automatic logic [W-1:0] drive_of(input logic oen);
      return oen ? '0 : '1;
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      #1;
      chk({tag, " R7 drive"}, par_drive, drive_of(oe_n));
      chk({tag, " R2 data"}, par_data, exp_st);
      chk({tag, " R3 serial"}, {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, exp_sr[W-1]});
   endtask

   task automatic shift_pulse(input logic b);
      ser_in = b;
      #HALF shift_clk = 1'b1;
      if (clr_n) exp_sr = shifted(exp_sr, b);
      #HALF shift_clk = 1'b0;
   endtask

   task automatic store_pulse();
      #HALF store_clk = 1'b1;
      exp_st = clr_n ? exp_sr : '0;
      #HALF store_clk = 1'b0;
   endtask

   task automatic both_pulse(input logic b);
      ser_in = b;
      #HALF;
      shift_clk = 1'b1;
      store_clk = 1'b1;
      exp_st = clr_n ? exp_sr : '0;
      if (clr_n) exp_sr = shifted(exp_sr, b);
      #HALF;
      shift_clk = 1'b0;
      store_clk = 1'b0;
   endtask

   task automatic load_word(input logic [W-1:0] w);
      for (int i = W - 1; i >= 0; i--) shift_pulse(w[i]);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd595));
      // reset state: clear held across a shift edge and a store edge
      exp_sr = '0;
      shift_pulse(1'b1);            // R4 edge ignored under clear
      store_pulse();                // R6 loads zeros
      check_all("R4 R6 reset");
      #HALF clr_n = 1'b1;
      check_all("R4 after release");

      // R1: bit order, word 8'hA5 loaded MSB first
      load_word(8'hA5);
      chk("R1 serial after load", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, 1'b1});
      check_all("R1 load A5");
      store_pulse();
      oe_n = 1'b0;
      check_all("R2 store A5");
      chk("R2 word A5", par_data, 8'hA5);

      // R3: ser_out with outputs disabled
      oe_n = 1'b1;
      shift_pulse(1'b0);
      check_all("R3 oe high");

      // R8: toggle oe_n, registers unchanged
      for (int k = 0; k < 6; k++) begin
         #HALF oe_n = ~oe_n;
         check_all("R8 toggle");
      end
      oe_n = 1'b0;
      load_word(8'h3C);
      store_pulse();
      check_all("R8 after toggles");
      chk("R8 word 3C", par_data, 8'h3C);

      // R5: clear leaves storage alone; asynchronous clear seen without a clock
      #HALF clr_n = 1'b0;
      exp_sr = '0;
      check_all("R4 async clear");
      chk("R5 storage kept", par_data, 8'h3C);
      shift_pulse(1'b1);
      #HALF clr_n = 1'b1;
      check_all("R5 after clear");

      // R9: tied clocks
      load_word(8'hF0);
      store_pulse();
      both_pulse(1'b1);
      chk("R9 lag one pulse", par_data, 8'hF0);
      check_all("R9 tied");
      both_pulse(1'b0);
      chk("R9 second pulse", par_data, 8'hE1);
      check_all("R9 tied 2");

      // random mix
      for (int n = 0; n < N_RANDOM; n++) begin
         int op;
         op = $urandom_range(0, 9);
         if (op <= 3) begin
            shift_pulse(1'($urandom_range(0, 1)));
            check_all("R1 random shift");
         end else if (op == 4) begin
            store_pulse();
            check_all("R2 random store");
         end else if (op == 5) begin
            both_pulse(1'($urandom_range(0, 1)));
            check_all("R9 random tied");
         end else if (op == 6 || op == 7) begin
            #HALF oe_n = ~oe_n;
            check_all("R8 random toggle");
         end else begin
            #HALF clr_n = 1'b0;
            exp_sr = '0;
            shift_pulse(1'($urandom_range(0, 1)));
            if (op == 9) store_pulse();
            check_all("R5 R6 random clear");
            #HALF clr_n = 1'b1;
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule